// File: doc/BRIEF.md
# GPIO Port with Atomic Bit Operations

This block is a general-purpose I/O port of `NUM_PINS` pins (32 by default) that software reaches through a plain register bus. The bus has a word address, a write enable, write data and read data. Reads are combinational from the addressed register, and writes take effect at the clock edge where `we_i` is high. The port holds an output data register and a per-pin direction register, and these drive the pad output-value and output-enable vectors directly.

Three write-only alias addresses change output bits without a read-modify-write sequence. One drives the selected bits high, one drives them low, and one inverts them. Pins that the mask leaves at 0 keep their level. On the input side, the pad levels pass through a synchronizer into a data input register. A per-pin disable mask forces the reading of a disabled pin to 0.

The update logic gives clear priority over set. Toggle acts only on bits that neither set nor clear targets. The single-write bus never presents more than one alias at a time, so this ordering only fixes how the three masks combine in the update logic.

Top module: `gpio_port`

## Requirements
- R1: After reset the output data, direction and input-disable registers are all zero, so `pad_out_o` and `pad_oe_o` are zero.
- R2: Word address 1 is the direction register, read/write. Bit n = 1 makes pin n an output (`pad_oe_o[n]`=1), and bit n = 0 makes it an input.
- R3: Word address 0 is the output data register, read/write, driven onto `pad_out_o`. It keeps its value in every cycle without a write that targets it.
- R4: A write to address 2 (set alias) makes every output bit whose mask bit is 1 high and leaves the others unchanged.
- R5: A write to address 3 (clear alias) makes every output bit whose mask bit is 1 low and leaves the others unchanged.
- R6: A write to address 4 (toggle alias) inverts every output bit whose mask bit is 1 and leaves the others unchanged.
- R7: Addresses 2, 3 and 4 read back as zero.
- R8: Address 5 reads the pin levels, with bit n holding pin n. A pad change that is set up before clock edge k is visible after edge k+1 (two-flop synchronizer). Writes to this address have no effect.
- R9: Address 6 is the input-disable register, read/write. A 1 disables digital input for that pin, which then reads 0 at address 5. A 0 enables the input.
- R10: Addresses 7 to 15 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Word address of the register |
| we_i | input | 1 | Write strobe, sampled at the clock edge |
| wdata_i | input | NUM_PINS | Write data / bit mask |
| rdata_o | output | NUM_PINS | Read data of the addressed register |
| pad_in_i | input | NUM_PINS | Levels seen at the pads |
| pad_out_o | output | NUM_PINS | Output value to the pad drivers |
| pad_oe_o | output | NUM_PINS | Output enable to the pad drivers |

## Verification
The hardest case to reach is the input path, where two delays overlap: the synchronizer latency and the disable mask. A pad change must be observed one cycle too early and then exactly on time, with some pins disabled at that moment. Directed steps change `pad_in_i` at a falling edge and read the input register after one and after two rising edges, under a non-trivial disable mask. A random phase then interleaves alias writes, disable-mask updates and pad changes, and re-reads every register against a bench model.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    REG_DOUT = 4'd0,
    REG_DIR  = 4'd1,
    REG_SET  = 4'd2,
    REG_CLR  = 4'd3,
    REG_TGL  = 4'd4,
    REG_DIN  = 4'd5,
    REG_IDIS = 4'd6
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_out_ctl.sv
module gpio_out_ctl #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_dout_i,
  input  logic         wr_dir_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] tgl_i,
  output logic [W-1:0] dout_o,
  output logic [W-1:0] dir_o
);
  logic [W-1:0] dout_q, dout_d, dir_q;

  // per bit: clear beats set, toggle only when untouched by either
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      if (wr_dout_i)      dout_d[b] = wdata_i[b];
      else if (clr_i[b])  dout_d[b] = 1'b0;
      else if (set_i[b])  dout_d[b] = 1'b1;
      else if (tgl_i[b])  dout_d[b] = ~dout_q[b];
      else                dout_d[b] = dout_q[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      dout_q <= dout_d;
      if (wr_dir_i) dir_q <= wdata_i;
    end
  end

  assign dout_o = dout_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/gpio_in_path.sv
module gpio_in_path #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pad_in_i,
  input  logic         wr_idis_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] idis_o,
  output logic [W-1:0] din_o
);
  logic [W-1:0] idis_q, sync_q;

  gpio_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idis_q <= '0;
    else if (wr_idis_i) idis_q <= wdata_i;
  end

  assign idis_o = idis_q;
  assign din_o  = sync_q & ~idis_q;
endmodule

// File: rtl/gpio_bus_dec.sv
module gpio_bus_dec
  import gpio_port_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [REG_AW-1:0] addr_i,
  input  logic              we_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      dout_i,
  input  logic [W-1:0]      dir_i,
  input  logic [W-1:0]      idis_i,
  input  logic [W-1:0]      din_i,
  output logic              wr_dout_o,
  output logic              wr_dir_o,
  output logic              wr_idis_o,
  output logic [W-1:0]      set_o,
  output logic [W-1:0]      clr_o,
  output logic [W-1:0]      tgl_o,
  output logic [W-1:0]      rdata_o
);
  assign wr_dout_o = we_i && (addr_i == REG_DOUT);
  assign wr_dir_o  = we_i && (addr_i == REG_DIR);
  assign wr_idis_o = we_i && (addr_i == REG_IDIS);
  assign set_o = (we_i && addr_i == REG_SET) ? wdata_i : '0;
  assign clr_o = (we_i && addr_i == REG_CLR) ? wdata_i : '0;
  assign tgl_o = (we_i && addr_i == REG_TGL) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      REG_DOUT: rdata_o = dout_i;
      REG_DIR:  rdata_o = dir_i;
      REG_DIN:  rdata_o = din_i;
      REG_IDIS: rdata_o = idis_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic                we_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  logic                wr_dout, wr_dir, wr_idis;
  logic [NUM_PINS-1:0] set_m, clr_m, tgl_m;
  logic [NUM_PINS-1:0] dout_q, dir_q, idis_q, din;

  gpio_bus_dec #(.W(NUM_PINS)) u_dec (
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .dout_i   (dout_q),
    .dir_i    (dir_q),
    .idis_i   (idis_q),
    .din_i    (din),
    .wr_dout_o(wr_dout),
    .wr_dir_o (wr_dir),
    .wr_idis_o(wr_idis),
    .set_o    (set_m),
    .clr_o    (clr_m),
    .tgl_o    (tgl_m),
    .rdata_o  (rdata_o)
  );

  gpio_out_ctl #(.W(NUM_PINS)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_dout_i(wr_dout),
    .wr_dir_i (wr_dir),
    .wdata_i  (wdata_i),
    .set_i    (set_m),
    .clr_i    (clr_m),
    .tgl_i    (tgl_m),
    .dout_o   (dout_q),
    .dir_o    (dir_q)
  );

  gpio_in_path #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_in (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pad_in_i (pad_in_i),
    .wr_idis_i(wr_idis),
    .wdata_i  (wdata_i),
    .idis_o   (idis_q),
    .din_o    (din)
  );

  assign pad_out_o = dout_q;
  assign pad_oe_o  = dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [REG_AW-1:0]   addr_i,
  input logic                we_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] rdata_o,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] idis_i
);
  AST_SET_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_SET) |=> ((pad_out_o & $past(wdata_i)) == $past(wdata_i))); // R4

  AST_CLR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_CLR) |=> ((pad_out_o & $past(wdata_i)) == '0)); // R5

  AST_TGL_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_TGL) |=> (pad_out_o == ($past(pad_out_o) ^ $past(wdata_i)))); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(pad_out_o) && $stable(pad_oe_o))); // R3

  AST_ALIAS_RD0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_SET || addr_i == REG_CLR || addr_i == REG_TGL) |-> (rdata_o == '0)); // R7

  AST_IDIS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_DIN) |-> ((rdata_o & idis_i) == '0)); // R9

  AST_UNMAP_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i > REG_IDIS) |=> ($stable(pad_out_o) && $stable(pad_oe_o))); // R10
endmodule

bind gpio_port gpio_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pad_out_o(pad_out_o),
  .pad_oe_o (pad_oe_o),
  .idis_i   (idis_q)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   addr = '0;
  logic         we = 1'b0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [N-1:0] m_dout = '0, m_dir = '0, m_idis = '0;

  always #4 clk = ~clk;

  gpio_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R3";
      4'd1: return "R2";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      4'd5: return "R8";
      4'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic void model_wr(input logic [3:0] a, input logic [N-1:0] d);
    case (a)
      4'd0: m_dout = d;
      4'd1: m_dir = d;
      4'd2: m_dout = m_dout | d;
      4'd3: m_dout = m_dout & ~d;
      4'd4: m_dout = m_dout ^ d;
      4'd6: m_idis = d;
      default: ;
    endcase
  endfunction

  function automatic logic [N-1:0] model_rd(input logic [3:0] a);
    case (a)
      4'd0: return m_dout;
      4'd1: return m_dir;
      4'd5: return pad_in & ~m_idis;
      4'd6: return m_idis;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [N-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic check_pads(input string tag);
    check(tag, pad_out, m_dout);
    check(tag, pad_oe, m_dir);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    check_pads("R1");
    bus_rd(4'd6, r); check("R1", r, '0);

    // R3 direct write and hold
    bus_wr(4'd0, 32'hA5A5_0F0F); check_pads("R3");
    repeat (4) @(negedge clk);
    check_pads("R3");
    bus_rd(4'd0, r); check("R3", r, 32'hA5A5_0F0F);
    // R2 direction
    bus_wr(4'd1, 32'hFFFF_0000); check_pads("R2");
    bus_rd(4'd1, r); check("R2", r, 32'hFFFF_0000);
    // R4 R5 R6 corner masks
    bus_wr(4'd2, 32'hFFFF_FFFF); check_pads("R4");
    bus_wr(4'd3, 32'h8000_0001); check_pads("R5");
    bus_wr(4'd4, 32'h0000_0000); check_pads("R6");
    bus_wr(4'd4, 32'hFFFF_FFFF); check_pads("R6");
    bus_wr(4'd2, 32'h0000_0000); check_pads("R4");
    // R7 alias reads
    bus_rd(4'd2, r); check("R7", r, '0);
    bus_rd(4'd3, r); check("R7", r, '0);
    bus_rd(4'd4, r); check("R7", r, '0);
    // R10 unmapped
    bus_wr(4'd9, 32'h1234_5678); check_pads("R10");
    bus_rd(4'd15, r); check("R10", r, '0);

    // R8 synchronizer latency
    pad_in = 32'h0000_FFFF;
    repeat (3) @(negedge clk);
    bus_wr(4'd6, 32'h0000_00F0);
    @(negedge clk);
    pad_in = 32'hFFFF_0000;
    @(posedge clk); #1;
    addr = 4'd5; #1;
    check("R8", rdata, 32'h0000_FFFF & ~32'h0000_00F0);
    @(posedge clk); #2;
    check("R8", rdata, 32'hFFFF_0000 & ~32'h0000_00F0);
    // R8 writes to input register ignored
    bus_wr(4'd5, 32'hDEAD_BEEF); check_pads("R8");
    bus_rd(4'd5, r); check("R8", r, 32'hFFFF_0000);
    // R9 disable and re-enable
    bus_wr(4'd6, 32'hFFFF_FFFF);
    bus_rd(4'd5, r); check("R9", r, '0);
    bus_wr(4'd6, 32'h0000_0000);
    bus_rd(4'd5, r); check("R9", r, 32'hFFFF_0000);

    // random phase
    for (int it = 0; it < 400; it++) begin
      logic [3:0] a;
      logic [N-1:0] d;
      a = 4'($urandom % 16);
      if (a > 4'd7 && ($urandom % 4) != 0) a = 4'($urandom % 7);
      d = $urandom;
      bus_wr(a, d);
      check_pads(tag_of(a));
      a = 4'($urandom % 16);
      bus_rd(a, r);
      check(a == 4'd5 ? "R8" : (a inside {4'd2, 4'd3, 4'd4}) ? "R7" : tag_of(a), r, model_rd(a));
      if (it % 8 == 0) begin
        pad_in = $urandom;
        repeat (3) @(negedge clk);
        bus_rd(4'd5, r); check("R9", r, model_rd(4'd5));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule